// File: doc/BRIEF.md
# Transmit Queue Status Interrupt Generator

This block sits beside the transmit queue of a node's link interface and watches two things: how full the queue is, and whether the receive side has flagged a corrupt transfer. From these it raises a local status interrupt, keeps a small set of status bits for the host to read, and decides whether each host write may enter the queue.

A host write that arrives while the queue is more than half full is still accepted, but it produces an interrupt pulse. A host write that arrives while the queue is full, with the half-full condition also present, is refused. The refused write never reaches the queue, and a one-cycle bus-error strobe answers it. A corrupt-transfer report also raises the interrupt. A separate mask can silence that report on its own, so that redundant transfer operation runs without error interrupts. A global enable gates both interrupt sources. The corrupt-transfer event is kept in a sticky status bit that the host clears by writing 1.

The queue storage, the link transmitter and the interrupt controller lie outside this block.

Top module: `txq_status_irq`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `irq`, `bus_err`, `stat_half`, `stat_full` and `stat_corrupt` are 0.
- R2: A cycle with `host_wr`=1, the over-half condition true and `irq_enable`=1 makes `irq` 1 for exactly the following cycle.
- R3: A host write while the over-half condition is false raises no interrupt.
- R4: The over-half condition is true when `fifo_half`=1 or `fifo_level` > DEPTH/2 (with DEPTH=512: a level of 257 qualifies and a level of 256 does not). The full condition is true when `fifo_full`=1 or `fifo_level` >= DEPTH.
- R5: A host write while both the full and the over-half conditions are true is refused. `fifo_push` stays 0 in that same cycle and `bus_err` is 1 for exactly the following cycle. Full without over-half does not refuse.
- R6: A host write that is not refused drives `fifo_push`=1 in the same cycle, and `bus_err` stays 0. `fifo_push` is never 1 without `host_wr`.
- R7: `corrupt_pulse`=1 with `corrupt_mask`=0 and `irq_enable`=1 makes `irq` 1 in the following cycle.
- R8: With `corrupt_mask`=1, `corrupt_pulse` raises no interrupt, but it still sets `stat_corrupt`.
- R9: With `irq_enable`=0, neither source raises `irq`.
- R10: `stat_corrupt` becomes 1 the cycle after any `corrupt_pulse` and holds until a cycle with `clr_corrupt`=1 and no `corrupt_pulse`. A set in the same cycle as a clear wins.
- R11: `stat_half` and `stat_full` show the over-half and full conditions of the previous cycle.
- R12: Simultaneous qualifying events in one cycle produce a single one-cycle `irq` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe toward the transmit queue |
| fifo_level | input | LVL_W (10) | Current queue occupancy in words |
| fifo_full | input | 1 | Full flag from the queue |
| fifo_half | input | 1 | Over-half flag from the queue |
| corrupt_pulse | input | 1 | One-cycle report of a corrupt received transfer |
| irq_enable | input | 1 | Global status interrupt enable |
| corrupt_mask | input | 1 | 1 suppresses interrupts from corrupt transfers |
| clr_corrupt | input | 1 | Write-1-to-clear strobe for the sticky corrupt bit |
| fifo_push | output | 1 | Accepted write, forwarded to the queue |
| bus_err | output | 1 | One-cycle bus-error answer to a refused write |
| irq | output | 1 | One-cycle status interrupt request |
| stat_half | output | 1 | Status bit: queue over half full |
| stat_full | output | 1 | Status bit: queue full |
| stat_corrupt | output | 1 | Sticky status bit: corrupt transfer seen |

## Verification
On every cycle the assertions check that a refused write never pushes and is always answered by a bus error one cycle later, that a push only follows a host write, that an enabled over-half write always produces the interrupt, that no interrupt appears without the enable, and that a corrupt report always sets the sticky bit. Only the bench's scenarios can show the exact boundaries: level 256 against 257, full without half-full, clear colliding with set, and merged events giving one pulse instead of two. They also show that the mask silences the interrupt while the status bit still records the event.

// File: rtl/txq_stat_pkg.sv
package txq_stat_pkg;

  // occupancy strictly above the midpoint
  function automatic logic level_above_half(int unsigned lvl, int unsigned depth);
    return lvl > (depth / 2);
  endfunction

  // occupancy at or beyond capacity
  function automatic logic level_at_full(int unsigned lvl, int unsigned depth);
    return lvl >= depth;
  endfunction

  // write refusal rule: full and over-half must both hold
  function automatic logic write_refused(logic wr, logic full, logic over_half);
    return wr & full & over_half;
  endfunction

  typedef struct packed {
    logic half;
    logic full;
    logic corrupt;
  } txq_status_t;

endpackage

// File: rtl/txq_occ_decode.sv
module txq_occ_decode
  import txq_stat_pkg::*;
#(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic [LVL_W-1:0] level,
  input  logic             full_flag,
  input  logic             half_flag,
  output logic             over_half,
  output logic             is_full
);
  logic lvl_half, lvl_full;

  always_comb begin
    lvl_half  = level_above_half(32'(level), DEPTH);
    lvl_full  = level_at_full(32'(level), DEPTH);
    over_half = half_flag | lvl_half;
    is_full   = full_flag | lvl_full;
  end
endmodule

// File: rtl/txq_wr_gate.sv
module txq_wr_gate
  import txq_stat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic host_wr,
  input  logic over_half,
  input  logic is_full,
  output logic fifo_push,
  output logic wr_reject,
  output logic wr_half_evt,
  output logic bus_err
);
  always_comb begin
    wr_reject   = write_refused(host_wr, is_full, over_half);
    fifo_push   = host_wr & ~wr_reject;
    wr_half_evt = host_wr & over_half;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_err <= 1'b0;
    else        bus_err <= wr_reject;
  end
endmodule

// File: rtl/txq_irq_gen.sv
module txq_irq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_half_evt,
  input  logic corrupt_pulse,
  input  logic irq_enable,
  input  logic corrupt_mask,
  output logic corrupt_evt,
  output logic irq_evt,
  output logic irq
);
  always_comb begin
    corrupt_evt = corrupt_pulse & ~corrupt_mask;
    irq_evt     = irq_enable & (wr_half_evt | corrupt_evt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_evt;
  end
endmodule

// File: rtl/txq_status_regs.sv
module txq_status_regs
  import txq_stat_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        over_half,
  input  logic        is_full,
  input  logic        corrupt_pulse,
  input  logic        clr_corrupt,
  output txq_status_t status
);
  txq_status_t nxt;

  always_comb begin
    nxt.half    = over_half;
    nxt.full    = is_full;
    nxt.corrupt = corrupt_pulse | (status.corrupt & ~clr_corrupt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= nxt;
  end
endmodule

// File: rtl/txq_status_irq.sv
module txq_status_irq
  import txq_stat_pkg::*;
#(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             fifo_full,
  input  logic             fifo_half,
  input  logic             corrupt_pulse,
  input  logic             irq_enable,
  input  logic             corrupt_mask,
  input  logic             clr_corrupt,
  output logic             fifo_push,
  output logic             bus_err,
  output logic             irq,
  output logic             stat_half,
  output logic             stat_full,
  output logic             stat_corrupt
);
  logic        over_half, is_full;
  logic        wr_reject, wr_half_evt;
  logic        corrupt_evt, irq_evt;
  txq_status_t status;

  txq_occ_decode #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_dec (
    .level(fifo_level), .full_flag(fifo_full), .half_flag(fifo_half),
    .over_half(over_half), .is_full(is_full)
  );

  txq_wr_gate u_gate (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr),
    .over_half(over_half), .is_full(is_full),
    .fifo_push(fifo_push), .wr_reject(wr_reject),
    .wr_half_evt(wr_half_evt), .bus_err(bus_err)
  );

  txq_irq_gen u_irq (
    .clk(clk), .rst_n(rst_n), .wr_half_evt(wr_half_evt),
    .corrupt_pulse(corrupt_pulse), .irq_enable(irq_enable),
    .corrupt_mask(corrupt_mask), .corrupt_evt(corrupt_evt),
    .irq_evt(irq_evt), .irq(irq)
  );

  txq_status_regs u_stat (
    .clk(clk), .rst_n(rst_n), .over_half(over_half), .is_full(is_full),
    .corrupt_pulse(corrupt_pulse), .clr_corrupt(clr_corrupt),
    .status(status)
  );

  assign stat_half    = status.half;
  assign stat_full    = status.full;
  assign stat_corrupt = status.corrupt;
endmodule

// File: rtl/txq_status_irq_chk.sv
module txq_status_irq_chk (
  input logic clk,
  input logic rst_n,
  input logic host_wr,
  input logic fifo_push,
  input logic bus_err,
  input logic irq,
  input logic irq_enable,
  input logic corrupt_pulse,
  input logic stat_corrupt,
  input logic wr_reject,
  input logic over_half
);
  AST_REJECT_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |-> !fifo_push);                                   // R5
  AST_BERR_AFTER_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> bus_err);                                      // R5
  AST_PUSH_NEEDS_WR: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> host_wr);                                      // R6
  AST_HALF_WR_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && over_half && irq_enable) |=> irq);               // R2
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(irq_enable));                                  // R9
  AST_CORRUPT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    corrupt_pulse |=> stat_corrupt);                             // R10
endmodule

bind txq_status_irq txq_status_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .fifo_push(fifo_push),
  .bus_err(bus_err), .irq(irq), .irq_enable(irq_enable),
  .corrupt_pulse(corrupt_pulse), .stat_corrupt(stat_corrupt),
  .wr_reject(wr_reject), .over_half(over_half)
);

// File: tb/tb_txq_status_irq.sv
`timescale 1ns/1ps
module tb_txq_status_irq;
  localparam int DEPTH = 512;
  localparam int LVL_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 0, fifo_full = 0, fifo_half = 0, corrupt_pulse = 0;
  logic irq_enable = 0, corrupt_mask = 0, clr_corrupt = 0;
  logic [LVL_W-1:0] fifo_level = '0;
  logic fifo_push, bus_err, irq, stat_half, stat_full, stat_corrupt;

  int compared = 0;
  int mismatched = 0;

  // reference state
  bit m_irq, m_berr, m_half, m_full, m_cor;

  always #2 clk = ~clk;

  txq_status_irq dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .fifo_level(fifo_level),
    .fifo_full(fifo_full), .fifo_half(fifo_half), .corrupt_pulse(corrupt_pulse),
    .irq_enable(irq_enable), .corrupt_mask(corrupt_mask), .clr_corrupt(clr_corrupt),
    .fifo_push(fifo_push), .bus_err(bus_err), .irq(irq),
    .stat_half(stat_half), .stat_full(stat_full), .stat_corrupt(stat_corrupt)
  );

  task automatic check(string tag, string what, logic act, bit exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_regs(string tag);
    check(tag, "irq", irq, m_irq);
    check(tag, "bus_err", bus_err, m_berr);
    check(tag, "stat_half", stat_half, m_half);
    check(tag, "stat_full", stat_full, m_full);
    check(tag, "stat_corrupt", stat_corrupt, m_cor);
  endtask

  // one clock: drive at negedge, check push, advance reference, check registers
  task automatic cyc(string tag, bit wr, int lvl, bit ff, bit hf,
                     bit cp, bit en, bit mk, bit clr);
    bit ov, fu, rej;
    host_wr = wr; fifo_level = LVL_W'(lvl); fifo_full = ff; fifo_half = hf;
    corrupt_pulse = cp; irq_enable = en; corrupt_mask = mk; clr_corrupt = clr;
    ov  = hf || (lvl > DEPTH / 2);
    fu  = ff || (lvl >= DEPTH);
    rej = wr && fu && ov;
    #1;
    check(tag, "fifo_push", fifo_push, wr && !rej);
    @(posedge clk);
    m_irq  = en && ((wr && ov) || (cp && !mk));
    m_berr = rej;
    m_half = ov;
    m_full = fu;
    m_cor  = cp || (m_cor && !clr);
    @(negedge clk);
    check_regs(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R1: reset state, held and just after release
    repeat (3) @(negedge clk);
    check_regs("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_regs("R1");

    // R3 and R6: accepted write below half
    cyc("R3", 1, 100, 0, 0, 0, 1, 0, 0);
    cyc("R6", 1, 0,   0, 0, 0, 1, 0, 0);
    // R4 boundary: 256 is not over half, 257 is
    cyc("R4", 1, 256, 0, 0, 0, 1, 0, 0);
    cyc("R4", 1, 257, 0, 0, 0, 1, 0, 0);
    cyc("R2", 0, 0,   0, 0, 0, 1, 0, 0);   // pulse ends after one cycle
    cyc("R4", 1, 10,  0, 1, 0, 1, 0, 0);   // half flag alone qualifies
    // R11: status follows without writes
    cyc("R11", 0, 300, 0, 0, 0, 1, 0, 0);
    cyc("R11", 0, 20,  0, 0, 0, 1, 0, 0);
    // R5: full by level, refused, bus error, still an interrupt
    cyc("R5", 1, 512, 0, 0, 0, 1, 0, 0);
    cyc("R5", 0, 512, 0, 0, 0, 1, 0, 0);
    cyc("R5", 1, 0,   1, 0, 0, 1, 0, 0);   // full flag without half: accepted
    cyc("R5", 1, 0,   1, 1, 0, 1, 0, 0);   // full and half flags: refused
    // R7, R10: corrupt report and sticky bit
    cyc("R7",  0, 0, 0, 0, 1, 1, 0, 0);
    cyc("R10", 0, 0, 0, 0, 0, 1, 0, 0);
    cyc("R10", 0, 0, 0, 0, 1, 1, 0, 1);    // set beats clear
    cyc("R10", 0, 0, 0, 0, 0, 1, 0, 1);    // clear
    cyc("R10", 0, 0, 0, 0, 0, 1, 0, 0);
    // R8: mask silences interrupt but not the status bit
    cyc("R8", 0, 0, 0, 0, 1, 1, 1, 0);
    cyc("R8", 0, 0, 0, 0, 0, 1, 1, 1);
    // R9: enable off blocks both sources
    cyc("R9", 1, 400, 0, 0, 1, 0, 0, 0);
    cyc("R9", 0, 0,   0, 0, 0, 0, 0, 1);
    // R12: both events together give one pulse
    cyc("R12", 1, 300, 0, 0, 1, 1, 0, 0);
    cyc("R12", 0, 0,   0, 0, 0, 1, 0, 1);

    // mixed traffic against the reference
    for (int i = 0; i < 400; i++) begin
      int lvl;
      lvl = int'($urandom_range(0, DEPTH));
      cyc("R2", bit'($urandom_range(0, 1)), lvl,
          bit'($urandom_range(0, 3) == 0), bit'($urandom_range(0, 3) == 0),
          bit'($urandom_range(0, 5) == 0), bit'($urandom_range(0, 3) != 0),
          bit'($urandom_range(0, 3) == 0), bit'($urandom_range(0, 4) == 0));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule